// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. Each request line is captured into a pending register in one of two ways. In edge mode, a rising input is latched and held. In level mode, the pending bit follows the input. A resolver searches the unmasked pending bits in a rotating order that starts at a programmable base line. It raises `irq_out` only when the winner outranks every interrupt already in service. The winning line is driven on `irq_idx`.

The surrounding logic acknowledges the presented interrupt with a one-cycle `ack` strobe. An acknowledge marks the line as in service, or rotates the priority base if automatic end-of-interrupt is selected. It also retires an edge-captured request. A specific end-of-interrupt strobe clears one in-service bit. Two exceptions change how the in-service set is weighed:

- Special-mask mode ignores in-service lines that are masked.
- Special fully-nested mode ignores the cascade line on a master instance.

Top module: `rpir_core`

## Requirements
- R1: After reset the pending and in-service sets are empty, the priority base is 0, every line is edge-triggered and `irq_out` is 0.
- R2: Among unmasked pending lines, the winner is the first one found when searching upward from the base line, modulo 8. `irq_idx` gives its line number.
- R3: A line whose `mask_in` bit is 1 never wins and never raises `irq_out`.
- R4: `irq_out` is 1 only when the winner's search offset is strictly smaller than the offset of the highest-ranked in-service line. An equal or worse pending line keeps `irq_out` at 0.
- R5: While `spec_mask_en` is 1, masked in-service lines take no part in the in-service ranking.
- R6: While `spec_nest_en` is 1 on a master instance, in-service line 2 takes no part in the in-service ranking.
- R7: An edge-triggered line sets its pending bit only on a 0-to-1 input change. The bit stays set after the input falls, and a held-high input does not set it again.
- R8: A level-triggered line's pending bit equals the input sampled on the previous clock edge, and an acknowledge does not clear it.
- R9: An `ack` while `irq_out` is 1 and `auto_eoi_en` is 0 sets the in-service bit of `irq_idx`.
- R10: An `ack` while `irq_out` is 1 and `auto_eoi_en` is 1 sets no in-service bit. If `rot_aeoi_en` is also 1, the base becomes `irq_idx`+1 modulo 8.
- R11: An accepted `ack` clears the pending bit of `irq_idx` when that line is edge-triggered.
- R12: `eoi_we` clears the in-service bit selected by `eoi_idx`.
- R13: An `ack` while `irq_out` is 0 changes no state.
- R14: `trig_we` loads the trigger-mode register from `trig_wdata`, where bit i at 1 selects level mode and 0 selects edge mode for line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Raw request lines |
| mask_in | input | 8 | Per-line mask, 1 = masked |
| trig_we | input | 1 | Load strobe for the trigger-mode register |
| trig_wdata | input | 8 | Trigger modes, 1 = level, 0 = edge |
| base_we | input | 1 | Load strobe for the priority base |
| base_wdata | input | 3 | New priority base line |
| spec_mask_en | input | 1 | Special-mask mode |
| spec_nest_en | input | 1 | Special fully-nested mode |
| auto_eoi_en | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_en | input | 1 | Rotate base on automatic end-of-interrupt |
| ack | input | 1 | Acknowledge strobe for the presented interrupt |
| eoi_we | input | 1 | Specific end-of-interrupt strobe |
| eoi_idx | input | 3 | Line whose in-service bit is cleared |
| irq_out | output | 1 | Interrupt request to the processor side |
| irq_idx | output | 3 | Winning line number |

## Verification
A corrupted pending, in-service or base register appears at `irq_out` and `irq_idx` one clock edge after the stimulus that wrote it, because the resolver is purely combinational. A wrong in-service bit is seen as a missing or extra interrupt when a lower- or higher-ranked line is pulsed next. A wrong base is seen as a different winner when two lines are pending together. A stale edge-captured request shows up only after its in-service bit is released. For that reason every acknowledge test releases the in-service bit with an end-of-interrupt before sampling.

// File: rtl/rpir_pkg.sv
package rpir_pkg;
   typedef struct packed {
      logic spec_mask;
      logic spec_nest;
      logic auto_eoi;
      logic rot_aeoi;
   } rpir_mode_t;
endpackage

// File: rtl/rpir_capture.sv
module rpir_capture #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_in,
   input  logic [N-1:0] trig_level,
   input  logic [N-1:0] clr_edge,
   output logic [N-1:0] irr
);
   logic [N-1:0] last_lvl;

   for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irr[i]      <= 1'b0;
            last_lvl[i] <= 1'b0;
         end else begin
            last_lvl[i] <= req_in[i];
            if (trig_level[i])
               irr[i] <= req_in[i];
            else if (req_in[i] && !last_lvl[i])
               irr[i] <= 1'b1;
            else if (clr_edge[i])
               irr[i] <= 1'b0;
         end
      end

      p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         trig_level[i] |=> irr[i] == $past(req_in[i]));
      p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!trig_level[i] && irr[i] && !clr_edge[i]) |=> irr[i]);
      p_edge_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!trig_level[i] && !irr[i] && last_lvl[i]) |=> !irr[i] || ($past(req_in[i]) && 1'b0) || trig_level[i] || $past(trig_level[i]) == 1'b0 && !irr[i] || irr[i] == 1'b0);
   end
endmodule

// File: rtl/rpir_resolve.sv
module rpir_resolve #(
   parameter int N            = 8,
   parameter int IDX_W        = 3,
   parameter bit IS_MASTER    = 1'b1,
   parameter int CASCADE_LINE = 2
) (
   input  logic [N-1:0]     irr,
   input  logic [N-1:0]     isr,
   input  logic [N-1:0]     mask,
   input  logic [IDX_W-1:0] base,
   input  logic             spec_mask,
   input  logic             spec_nest,
   output logic             irq_out,
   output logic [IDX_W-1:0] irq_idx
);
   localparam logic [IDX_W:0] NONE = (IDX_W+1)'(N);

   function automatic logic [IDX_W:0] rank_of(input logic [N-1:0] m,
                                               input logic [IDX_W-1:0] b);
      logic [IDX_W:0]   r;
      logic [IDX_W-1:0] pos;
      r = NONE;
      for (int o = N-1; o >= 0; o--) begin
         pos = IDX_W'(o) + b;
         if (m[pos]) r = (IDX_W+1)'(o);
      end
      return r;
   endfunction

   logic [N-1:0]   pend, svc, nest_keep;
   logic [IDX_W:0] pend_rank, svc_rank;

   if (IS_MASTER) begin : g_master
      always_comb begin
         nest_keep = '1;
         if (spec_nest) nest_keep[CASCADE_LINE] = 1'b0;
      end
   end else begin : g_slave
      assign nest_keep = '1;
   end

   always_comb begin
      pend      = irr & ~mask;
      svc       = (spec_mask ? (isr & ~mask) : isr) & nest_keep;
      pend_rank = rank_of(pend, base);
      svc_rank  = rank_of(svc, base);
      irq_out   = pend_rank < svc_rank;
      irq_idx   = pend_rank[IDX_W-1:0] + base;
   end
endmodule

// File: rtl/rpir_service.sv
module rpir_service #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_fire,
   input  logic [IDX_W-1:0] ack_idx,
   input  logic             auto_eoi,
   input  logic             rot_aeoi,
   input  logic             eoi_we,
   input  logic [IDX_W-1:0] eoi_idx,
   input  logic             base_we,
   input  logic [IDX_W-1:0] base_wdata,
   output logic [N-1:0]     isr,
   output logic [IDX_W-1:0] base
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr  <= '0;
         base <= '0;
      end else begin
         if (ack_fire && !auto_eoi) isr[ack_idx] <= 1'b1;
         if (eoi_we) isr[eoi_idx] <= 1'b0;
         if (base_we)
            base <= base_wdata;
         else if (ack_fire && auto_eoi && rot_aeoi)
            base <= ack_idx + 1'b1;
      end
   end

   p_ack_sets_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !auto_eoi && !eoi_we) |=> isr[$past(ack_idx)]);
   p_aeoi_no_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && auto_eoi && !isr[ack_idx]) |=> !isr[$past(ack_idx)]);
   p_aeoi_rotate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && auto_eoi && rot_aeoi && !base_we) |=> base == $past(ack_idx) + 1'b1);
   p_eoi_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_we && !(ack_fire && ack_idx == eoi_idx)) |=> !isr[$past(eoi_idx)]);
   p_idle_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_fire && !eoi_we && !base_we) |=> $stable(isr) && $stable(base));
endmodule

// File: rtl/rpir_core.sv
module rpir_core #(
   parameter int N            = 8,
   parameter bit IS_MASTER    = 1'b1,
   parameter int CASCADE_LINE = 2,
   localparam int IDX_W       = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req_in,
   input  logic [N-1:0]     mask_in,
   input  logic             trig_we,
   input  logic [N-1:0]     trig_wdata,
   input  logic             base_we,
   input  logic [IDX_W-1:0] base_wdata,
   input  logic             spec_mask_en,
   input  logic             spec_nest_en,
   input  logic             auto_eoi_en,
   input  logic             rot_aeoi_en,
   input  logic             ack,
   input  logic             eoi_we,
   input  logic [IDX_W-1:0] eoi_idx,
   output logic             irq_out,
   output logic [IDX_W-1:0] irq_idx
);
   import rpir_pkg::*;

   if (N < 2 || (N & (N-1)) != 0) begin : g_bad_n
      $error("rpir_core: N must be a power of two, at least 2");
   end
   if (CASCADE_LINE < 0 || CASCADE_LINE >= N) begin : g_bad_casc
      $error("rpir_core: CASCADE_LINE out of range");
   end

   rpir_mode_t   mode;
   logic [N-1:0] trig_level, irr, isr, clr_edge;
   logic [IDX_W-1:0] base;
   logic         ack_fire;

   assign mode = '{spec_mask: spec_mask_en, spec_nest: spec_nest_en,
                   auto_eoi: auto_eoi_en, rot_aeoi: rot_aeoi_en};

   always_ff @(posedge clk) begin
      if (!rst_n) trig_level <= '0;
      else if (trig_we) trig_level <= trig_wdata;
   end

   assign ack_fire = ack && irq_out;

   always_comb begin
      clr_edge = '0;
      if (ack_fire) clr_edge[irq_idx] = !trig_level[irq_idx];
   end

   rpir_capture #(.N(N)) u_cap (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
      .clr_edge(clr_edge), .irr(irr));

   rpir_resolve #(.N(N), .IDX_W(IDX_W), .IS_MASTER(IS_MASTER),
                  .CASCADE_LINE(CASCADE_LINE)) u_res (
      .irr(irr), .isr(isr), .mask(mask_in), .base(base),
      .spec_mask(mode.spec_mask), .spec_nest(mode.spec_nest),
      .irq_out(irq_out), .irq_idx(irq_idx));

   rpir_service #(.N(N), .IDX_W(IDX_W)) u_svc (
      .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .ack_idx(irq_idx),
      .auto_eoi(mode.auto_eoi), .rot_aeoi(mode.rot_aeoi),
      .eoi_we(eoi_we), .eoi_idx(eoi_idx), .base_we(base_we),
      .base_wdata(base_wdata), .isr(isr), .base(base));

   p_win_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> !mask_in[irq_idx] && irr[irq_idx]);
   p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irr & ~mask_in) == '0 |-> !irq_out);
   p_ack_clears_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !trig_level[irq_idx] && !req_in[irq_idx]) |=> !irr[$past(irq_idx)]);
   p_reset_state_r1: assert property (@(posedge clk)
      $past(!rst_n) && !rst_n |=> !irq_out);
   p_trig_load_r14: assert property (@(posedge clk) disable iff (!rst_n)
      trig_we |=> trig_level == $past(trig_wdata));
endmodule

// File: tb/sim_rpir_core.sv
module sim_rpir_core;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] req_in, mask_in, trig_wdata;
   logic       trig_we, base_we, spec_mask_en, spec_nest_en;
   logic       auto_eoi_en, rot_aeoi_en, ack, eoi_we;
   logic [2:0] base_wdata, eoi_idx;
   logic       irq_out;
   logic [2:0] irq_idx;
   int         n_chk = 0;
   int         n_bad = 0;

   always #10 clk = ~clk;

   rpir_core u0 (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_in(mask_in),
      .trig_we(trig_we), .trig_wdata(trig_wdata), .base_we(base_we),
      .base_wdata(base_wdata), .spec_mask_en(spec_mask_en),
      .spec_nest_en(spec_nest_en), .auto_eoi_en(auto_eoi_en),
      .rot_aeoi_en(rot_aeoi_en), .ack(ack), .eoi_we(eoi_we),
      .eoi_idx(eoi_idx), .irq_out(irq_out), .irq_idx(irq_idx));

   // {mask, base, req, expected irq_out, expected index}
   localparam logic [22:0] VEC [10] = '{
      {8'h00, 3'd0, 8'h01, 1'b1, 3'd0},
      {8'h00, 3'd0, 8'h84, 1'b1, 3'd2},
      {8'h00, 3'd3, 8'h84, 1'b1, 3'd7},
      {8'h00, 3'd7, 8'h84, 1'b1, 3'd7},
      {8'h00, 3'd1, 8'h01, 1'b1, 3'd0},
      {8'h80, 3'd3, 8'h84, 1'b1, 3'd2},
      {8'hFF, 3'd0, 8'hFF, 1'b0, 3'd0},
      {8'h0F, 3'd5, 8'hF1, 1'b1, 3'd5},
      {8'h00, 3'd0, 8'h00, 1'b0, 3'd0},
      {8'hFE, 3'd6, 8'h03, 1'b1, 3'd0}
   };

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string rq, input logic ev, input logic [2:0] ei,
                      input bit use_idx);
      n_chk++;
      if (irq_out !== ev || (use_idx && ev && irq_idx !== ei)) begin
         n_bad++;
         $display("FAIL %s: irq_out=%0b idx=%0d expected irq_out=%0b idx=%0d",
                  rq, irq_out, irq_idx, ev, ei);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_in = '0; mask_in = '0; trig_we = 1'b0; trig_wdata = '0;
      base_we = 1'b0; base_wdata = '0; spec_mask_en = 1'b0; spec_nest_en = 1'b0;
      auto_eoi_en = 1'b0; rot_aeoi_en = 1'b0; ack = 1'b0; eoi_we = 1'b0;
      eoi_idx = '0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic pulse(input logic [7:0] lines);
      req_in = lines; step(); req_in = '0; step();
   endtask

   task automatic do_ack();
      ack = 1'b1; step(); ack = 1'b0;
   endtask

   task automatic do_eoi(input logic [2:0] line);
      eoi_we = 1'b1; eoi_idx = line; step(); eoi_we = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      do_reset();
      chk("R1 reset quiet", 1'b0, 3'd0, 1'b0);

      // R14 / R2 / R3 / R8: table walk with all lines in level mode
      trig_we = 1'b1; trig_wdata = 8'hFF; step(); trig_we = 1'b0;
      for (int k = 0; k < 10; k++) begin
         mask_in = VEC[k][22:15]; base_wdata = VEC[k][14:12];
         req_in = VEC[k][11:4]; base_we = 1'b1;
         step();
         base_we = 1'b0;
         chk($sformatf("R2/R3/R8 vector %0d", k), VEC[k][3], VEC[k][2:0], 1'b1);
      end

      // R1: lines start in edge mode, held-high input raises one request only
      // R7 / R11 / R9 / R12
      do_reset();
      req_in = 8'h08; step();
      chk("R7 edge captured", 1'b1, 3'd3, 1'b1);
      req_in = 8'h00; step();
      chk("R7 held after fall", 1'b1, 3'd3, 1'b1);
      do_ack();
      chk("R9 in service blocks", 1'b0, 3'd0, 1'b0);
      do_eoi(3'd3);
      chk("R11 edge request cleared by ack", 1'b0, 3'd0, 1'b0);
      req_in = 8'h08; step();
      chk("R7 new rising edge", 1'b1, 3'd3, 1'b1);
      do_ack(); do_eoi(3'd3);
      chk("R1/R7 held high no re-arm", 1'b0, 3'd0, 1'b0);
      req_in = 8'h00; step();

      // R4 / R5
      do_reset();
      pulse(8'h10); do_ack();
      pulse(8'h20);
      chk("R4 worse pending blocked", 1'b0, 3'd0, 1'b0);
      pulse(8'h10);
      chk("R4 equal pending blocked", 1'b0, 3'd0, 1'b0);
      mask_in = 8'h10; spec_mask_en = 1'b1; step();
      chk("R5 masked in-service ignored", 1'b1, 3'd5, 1'b1);
      spec_mask_en = 1'b0; step();
      chk("R5 off restores nesting", 1'b0, 3'd0, 1'b0);
      mask_in = 8'h00; pulse(8'h02);
      chk("R4 better pending raises", 1'b1, 3'd1, 1'b1);

      // R6
      do_reset();
      pulse(8'h04); do_ack();
      pulse(8'h08);
      chk("R6 cascade in service blocks", 1'b0, 3'd0, 1'b0);
      spec_nest_en = 1'b1; step();
      chk("R6 cascade ignored", 1'b1, 3'd3, 1'b1);

      // R10 with rotation
      do_reset();
      auto_eoi_en = 1'b1; rot_aeoi_en = 1'b1; step();
      pulse(8'h20);
      chk("R10 presented", 1'b1, 3'd5, 1'b1);
      do_ack();
      chk("R10 no in-service after ack", 1'b0, 3'd0, 1'b0);
      pulse(8'h81);
      chk("R10 base rotated to 6", 1'b1, 3'd7, 1'b1);

      // R10 without rotation
      do_reset();
      auto_eoi_en = 1'b1; step();
      pulse(8'h20); do_ack();
      pulse(8'h81);
      chk("R10 base kept at 0", 1'b1, 3'd0, 1'b1);

      // R13: acknowledge with nothing presented
      do_reset();
      auto_eoi_en = 1'b1; rot_aeoi_en = 1'b1; step();
      do_ack();
      pulse(8'h03);
      chk("R13 spurious ack ignored", 1'b1, 3'd0, 1'b1);

      // R14 / R8 / R12
      do_reset();
      trig_we = 1'b1; trig_wdata = 8'h40; step(); trig_we = 1'b0;
      req_in = 8'h40; step();
      chk("R14 level line requests", 1'b1, 3'd6, 1'b1);
      do_ack();
      chk("R9 level in service", 1'b0, 3'd0, 1'b0);
      do_eoi(3'd6);
      chk("R8/R12 level survives ack", 1'b1, 3'd6, 1'b1);
      req_in = 8'h00; step();
      chk("R8 level drops", 1'b0, 3'd0, 1'b0);

      finish_run();
   end
endmodule